// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller performs single external accesses of three kinds: program fetch, data read and data write. It uses a narrow pin set. The low address byte and the data byte share one 8-bit lane. The high address byte has a lane of its own. An address-latch pulse tells an external register when the low byte on the shared lane is valid. After that pulse, one of three active-low strobes runs the data phase.

On the core side, a caller presents a request with a kind, a 16-bit address and write data, and holds valid. The request is taken in any cycle in which the controller is idle. The access then passes through four fixed-length phases:
- address
- latch
- strobe
- a single closing cycle that carries a done pulse together with any read byte.

The shared lane is an output, an output enable and an input, so the pad ring can build the tri-state driver. All phase lengths are parameters.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the controller is idle. `req_ready`=1, `addr_latch`=0, all three strobes are high, `lo_oe`=0 and `done`=0.
- R2: In the cycle after a request is accepted, `addr_latch` rises and stays high for ADDR_CYC cycles. During that time `lo_oe`=1, `lo_out` carries address bits 7..0, and no strobe is low.
- R3: In the first cycle after `addr_latch` falls, the low address byte is still driven on `lo_out` with `lo_oe`=1.
- R4: `hi_out` equals address bits 15..8 in every cycle from the first address cycle through the closing cycle.
- R5: The kind encoding is 2'b00 = program fetch (`fetch_n`), 2'b01 = data read (`rd_n`), and 2'b1x = data write (`wr_n`). The selected strobe alone is low for STB_CYC consecutive cycles, starting ADDR_CYC+LATCH_CYC+1 cycles after acceptance. The other two strobes stay high.
- R6: For fetches and reads, `lo_oe` is 0 from the second latch cycle through the closing cycle. `rd_data` takes the value on `lo_in` during the last strobe-low cycle.
- R7: For writes, `lo_out` carries the write byte with `lo_oe`=1 from the second latch cycle through the closing cycle, that is, one cycle past the rise of `wr_n`.
- R8: `done` is high for exactly the one cycle after the last strobe-low cycle. `rd_data` is valid in that cycle.
- R9: `req_ready` is high only when idle. A request raised while busy is ignored, so no new address phase starts in the first idle cycle if valid has dropped by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 read, 1x write |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured on fetch/read |
| lo_out | output | 8 | Shared lane output value |
| lo_oe | output | 1 | Shared lane output enable |
| lo_in | input | 8 | Shared lane input value |
| hi_out | output | 8 | High address byte |
| addr_latch | output | 1 | Address-latch pulse, high active |
| fetch_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
Two events can meet in one cycle: a request arriving at the controller and the end of the previous access. The closing cycle of one access is immediately followed by an idle cycle in which a held request is accepted. A request raised during a busy access must not start a phase early, and it must not change the running access.

To provoke this, the bench keeps junk requests asserted through every other access and checks, cycle by cycle, that strobes, lane contents and the high byte still follow the original request. It then confirms that nothing starts once valid drops. For reads, the input lane changes value every cycle, so a capture taken one cycle early or late produces the wrong byte.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_LATCH = 3'd2,
        PH_STRB  = 3'd3,
        PH_END   = 3'd4
    } xbus_phase_e;

    localparam logic [1:0] KIND_FETCH = 2'b00;
    localparam logic [1:0] KIND_READ  = 2'b01;

    function automatic logic kind_is_write(input logic [1:0] k);
        return k[1];
    endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_CYC  = 2,
    parameter int LATCH_CYC = 2,
    parameter int STB_CYC   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output xbus_phase_e phase,
    output logic        last,
    output logic        latch_first
);

    localparam int MAXC_AL = (ADDR_CYC > LATCH_CYC) ? ADDR_CYC : LATCH_CYC;
    localparam int MAXC    = (MAXC_AL > STB_CYC) ? MAXC_AL : STB_CYC;
    localparam int CW      = $clog2(MAXC) + 1;
    localparam logic [CW-1:0] A_LD = CW'(ADDR_CYC - 1);
    localparam logic [CW-1:0] L_LD = CW'(LATCH_CYC - 1);
    localparam logic [CW-1:0] S_LD = CW'(STB_CYC - 1);

    typedef struct packed {
        xbus_phase_e     phase;
        logic [CW-1:0]   cnt;
    } seq_t;

    seq_t st_d, st_q;

    initial begin
        assert (ADDR_CYC >= 1 && LATCH_CYC >= 2 && STB_CYC >= 1)
            else $error("xbus_seq: phase lengths out of range");
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_ADDR;
                    st_d.cnt   = A_LD;
                end
            end
            PH_ADDR: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_LATCH;
                    st_d.cnt   = L_LD;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_LATCH: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_STRB;
                    st_d.cnt   = S_LD;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_STRB: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_END;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_END: begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase       = st_q.phase;
    assign last        = (st_q.cnt == '0);
    assign latch_first = (st_q.phase == PH_LATCH) && (st_q.cnt == L_LD);

    // R9: without a start the idle phase is kept
    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !start) |=> (phase == PH_IDLE));

    // R8: the closing phase lasts a single cycle
    p_end_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_END) |=> (phase == PH_IDLE));

    // R5: strobe phase is always entered from the latch phase
    p_strb_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase == PH_STRB) |-> ($past(phase) == PH_LATCH));

endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
    import xbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  req_kind,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    input  xbus_phase_e phase,
    input  logic        last,
    input  logic        latch_first,
    input  logic [7:0]  lo_in,
    output logic [7:0]  lo_out,
    output logic        lo_oe,
    output logic [7:0]  hi_out,
    output logic        addr_latch,
    output logic        fetch_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic        done,
    output logic [7:0]  rd_data
);

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [1:0]  kind;
        logic [7:0]  rdata;
    } lane_t;

    lane_t ln_d, ln_q;

    logic addr_on_lane;
    logic strobing;
    logic is_wr;

    always_comb begin
        ln_d = ln_q;
        if (start) begin
            ln_d.addr  = req_addr;
            ln_d.wdata = req_wdata;
            ln_d.kind  = req_kind;
        end
        if (phase == PH_STRB && last && !kind_is_write(ln_q.kind)) begin
            ln_d.rdata = lo_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    always_comb begin
        is_wr        = kind_is_write(ln_q.kind);
        addr_on_lane = (phase == PH_ADDR) || latch_first;
        strobing     = (phase == PH_STRB);
        addr_latch   = (phase == PH_ADDR);
        lo_oe        = addr_on_lane ||
                       (is_wr && ((phase == PH_LATCH) || strobing || (phase == PH_END)));
        lo_out       = addr_on_lane ? ln_q.addr[7:0] : ln_q.wdata;
        hi_out       = ln_q.addr[15:8];
        fetch_n      = !(strobing && ln_q.kind == KIND_FETCH);
        rd_n         = !(strobing && ln_q.kind == KIND_READ);
        wr_n         = !(strobing && is_wr);
        done         = (phase == PH_END);
        rd_data      = ln_q.rdata;
    end

    // R5: never more than one strobe low
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~fetch_n, ~rd_n, ~wr_n}) <= 1);

    // R2: no strobe while the address latch pulse is high
    p_latch_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch |-> (fetch_n && rd_n && wr_n));

    // R7: write strobe low only with the lane driven
    p_wr_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> lo_oe);

    // R6: read or fetch strobe low only with the lane released
    p_rd_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !fetch_n) |-> !lo_oe);

    // R4: high byte steady across a running access
    p_hi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(hi_out));

    // R3: first cycle after the latch pulse falls keeps the lane driven
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_latch) |-> lo_oe);

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_CYC  = 2,
    parameter int LATCH_CYC = 2,
    parameter int STB_CYC   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        req_ready,
    output logic        done,
    output logic [7:0]  rd_data,
    output logic [7:0]  lo_out,
    output logic        lo_oe,
    input  logic [7:0]  lo_in,
    output logic [7:0]  hi_out,
    output logic        addr_latch,
    output logic        fetch_n,
    output logic        rd_n,
    output logic        wr_n
);

    xbus_phase_e phase;
    logic        last;
    logic        latch_first;
    logic        start;

    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid && req_ready;

    xbus_seq #(
        .ADDR_CYC (ADDR_CYC),
        .LATCH_CYC(LATCH_CYC),
        .STB_CYC  (STB_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .phase      (phase),
        .last       (last),
        .latch_first(latch_first)
    );

    xbus_lane u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_kind   (req_kind),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .phase      (phase),
        .last       (last),
        .latch_first(latch_first),
        .lo_in      (lo_in),
        .lo_out     (lo_out),
        .lo_oe      (lo_oe),
        .hi_out     (hi_out),
        .addr_latch (addr_latch),
        .fetch_n    (fetch_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .done       (done),
        .rd_data    (rd_data)
    );

    // R8: done only right after a strobe-low cycle
    p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!fetch_n || !rd_n || !wr_n));

    // R9: ready and busy outputs are exclusive
    p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!addr_latch && !done && fetch_n && rd_n && wr_n));

endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;

    localparam int A    = 2;
    localparam int L    = 3;
    localparam int S    = 3;
    localparam int TEND = A + L + S + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done, lo_oe, addr_latch, fetch_n, rd_n, wr_n;
    logic [7:0]  rd_data, lo_out, hi_out;
    logic [7:0]  lo_in = '0;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xbus_ctrl #(.ADDR_CYC(A), .LATCH_CYC(L), .STB_CYC(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .lo_out(lo_out), .lo_oe(lo_oe),
        .lo_in(lo_in), .hi_out(hi_out), .addr_latch(addr_latch),
        .fetch_n(fetch_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] lane_pat(input int t, input logic [15:0] a);
        return 8'(t * 37) ^ a[7:0] ^ 8'h5A;
    endfunction

    task automatic run_access(input logic [1:0] kind, input logic [15:0] addr,
                              input logic [7:0] wd, input bit junk);
        logic wr;
        logic str;
        logic exp_oe;
        wr = kind[1];
        @(negedge clk);
        chk("R9 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_kind  = kind;
        req_addr  = addr;
        req_wdata = wd;
        for (int t = 1; t <= TEND + 1; t++) begin
            @(negedge clk);
            if (t <= TEND) begin
                str    = (t >= A + L + 1) && (t <= A + L + S);
                exp_oe = (t <= A + 1) || (wr && t >= A + 2);
                chk("R2 addr_latch", 32'(addr_latch), 32'(t <= A));
                chk("R5 fetch_n", 32'(fetch_n), 32'(!(str && kind == 2'b00)));
                chk("R5 rd_n", 32'(rd_n), 32'(!(str && kind == 2'b01)));
                chk("R5 wr_n", 32'(wr_n), 32'(!(str && wr)));
                chk(wr ? "R7 lo_oe" : "R6 lo_oe", 32'(lo_oe), 32'(exp_oe));
                if (t <= A + 1)
                    chk(t <= A ? "R2 low address" : "R3 address hold",
                        32'(lo_out), 32'(addr[7:0]));
                else if (wr)
                    chk("R7 write byte", 32'(lo_out), 32'(wd));
                chk("R4 hi_out", 32'(hi_out), 32'(addr[15:8]));
                chk("R8 done", 32'(done), 32'(t == TEND));
                chk("R9 ready busy", 32'(req_ready), 32'd0);
                if (t == TEND && !wr)
                    chk("R6 rd_data", 32'(rd_data), 32'(lane_pat(A + L + S, addr)));
            end else begin
                chk("R9 ignored while busy", 32'(addr_latch), 32'd0);
                chk("R9 ready after access", 32'(req_ready), 32'd1);
            end
            lo_in = lane_pat(t, addr);
            if (junk && t < TEND) begin
                req_valid = 1'b1;
                req_kind  = ~kind;
                req_addr  = ~addr;
                req_wdata = ~wd;
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 addr_latch", 32'(addr_latch), 32'd0);
        chk("R1 strobes", 32'({fetch_n, rd_n, wr_n}), 32'h7);
        chk("R1 lo_oe", 32'(lo_oe), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 32'(req_ready), 32'd1);
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 12; i++) begin
                run_access(2'(k), 16'(i * 16'h1357) ^ 16'hA5C3, 8'(i * 29 + k), (i % 2) == 1);
            end
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule